// File: doc/BRIEF.md
# Dual-Channel Bus-Master DMA Register Bank

This block is the host-visible register bank of a two-channel disk controller's bus-master DMA engine. The host reaches it through a simple byte-addressed port that carries an address, an access size and write data, and it returns read data. The bank occupies a 16-byte region. Each channel owns an 8-byte slot. The lower four bytes of a slot hold that channel's registers. The upper four bytes belong to the descriptor-address port, which lives outside this bank.

Each channel has a command byte, a status byte and a timing byte. Both channels also see one shared mode byte. The mode byte records each channel's interrupt request and holds a host-writable block bit per channel. The bank merges the two requests into a single level-sensitive host interrupt and honours the block bits. When the host sets a channel's start bit, the bank emits a one-cycle start strobe to the DMA engine.

Top module: `dmareg_bank`

## Requirements
- R1: After reset every stored bit is zero. All register bytes read 0x00 (with the busy inputs low), `host_irq` is low and `dma_go` is 0.
- R2: Only `acc_size` = 0 (one byte) is honoured. A read with size 1 (two bytes) returns 0x0000FFFF. A read with size 2 or 3 (four bytes) returns 0xFFFFFFFF. A write of any size other than 0 changes nothing.
- R3: Address bit 3 selects the channel and bits [1:0] select the register: 0 command, 1 mode, 2 status, 3 timing. When address bit 2 is 1 (the descriptor port), a byte read returns 0x000000FF and a write is ignored. A byte read of a bank register returns the byte in bits [7:0] with zeros above.
- R4: A command write stores bit 0 (start) and bit 3 (direction) of the data. All other command bits read as zero.
- R5: `dma_go[c]` is high for exactly one cycle, the cycle after the clock edge of a command write to channel c that sets bit 0 while the stored bit 0 is 0. Rewriting a start bit that is already 1 gives no pulse.
- R6: The mode byte holds the channel-0 request at bit 2, the channel-1 request at bit 3, the channel-0 block at bit 4 and the channel-1 block at bit 5. All other bits read zero. A host write changes only bits 5:4. Both channel windows read and write the same byte.
- R7: The request bit of channel c in the mode byte takes the value `chan_irq[c]` had at the previous clock edge.
- R8: `host_irq` equals (req0 AND NOT blk0) OR (req1 AND NOT blk1), evaluated on the stored mode bits. A request or block change therefore shows on `host_irq` one cycle after the edge that stores it.
- R9: Status bit 0 reads `chan_busy[c]` live. Bits 6:5 store the written data. Bit 1 and bits 7, 4 and 3 read zero.
- R10: Status bit 2 is set on the edge after `chan_irq[c]` is seen high while the stored request is low. A status write with data bit 2 = 1 clears it, and data bit 2 = 0 keeps it. If a rise and a clearing write meet on the same edge, the bit ends up set.
- R11: Each channel has its own 8-bit timing byte that stores all written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (4) | Byte address within the 16-byte region |
| acc_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| acc_wdata | input | DATA_W (32) | Write data (byte in [7:0]) |
| acc_rdata | output | DATA_W (32) | Combinational read data for the current address and size |
| chan_irq | input | 2 | Per-channel interrupt request level |
| chan_busy | input | 2 | Per-channel DMA active level |
| host_irq | output | 1 | Merged level-sensitive host interrupt |
| dma_go | output | 2 | One-cycle start strobe per channel |

## Verification
The assertions assume that `chan_irq`, `chan_busy` and every access field are synchronous to `clk` and hold steady for a whole cycle. They also assume that a write is recognised on the single edge where `acc_valid` and `acc_write` are both high. The stimulus meets these assumptions by changing every input only at the falling edge, through one sequential driver task. A behavioural model steps on the same values after each rising edge. Random phases mix wide accesses, descriptor-port addresses and interrupt toggles. The model must match the block even when a request rises on the same edge that a clearing status write lands.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

  localparam int NUM_CH = 2;
  localparam int BYTE_W = 8;

  // mode byte layout: requests from REQ_LSB, blocks from BLK_LSB
  localparam int REQ_LSB = 2;
  localparam int BLK_LSB = 4;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_MODE = 2'd1,
    REG_STAT = 2'd2,
    REG_TIME = 2'd3
  } reg_sel_e;

  // a request passes when it is set and its channel is not blocked
  function automatic logic irq_merge(input logic [NUM_CH-1:0] req,
                                     input logic [NUM_CH-1:0] blk);
    return |(req & ~blk);
  endfunction

  // interrupt flag: a rise sets it, and a written one clears it unless a rise arrives too
  function automatic logic flag_next(input logic flag, input logic rise,
                                     input logic wr, input logic wbit);
    return rise | (flag & ~(wr & wbit));
  endfunction

  function automatic logic [BYTE_W-1:0] stat_pack(input logic [1:0] hi,
                                                  input logic flag,
                                                  input logic busy);
    return {1'b0, hi, 2'b00, flag, 1'b0, busy};
  endfunction

  function automatic logic [BYTE_W-1:0] mode_pack(input logic [NUM_CH-1:0] req,
                                                  input logic [NUM_CH-1:0] blk);
    logic [BYTE_W-1:0] m;
    m = '0;
    m[REQ_LSB +: NUM_CH] = req;
    m[BLK_LSB +: NUM_CH] = blk;
    return m;
  endfunction

endpackage

// File: rtl/dmareg_chan.sv
module dmareg_chan
  import dmareg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cmd,
  input  logic              wr_stat,
  input  logic              wr_time,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              irq_in,
  input  logic              busy_in,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic [BYTE_W-1:0] stat_byte,
  output logic [BYTE_W-1:0] time_byte,
  output logic              irq_flag,
  output logic              go_pulse
);

  logic       start_q, dir_q, flag_q, req_q, go_q;
  logic [1:0] hi_q;
  logic [BYTE_W-1:0] time_q;

  // named events
  logic irq_rise;
  logic go_evt;
  assign irq_rise = irq_in & ~req_q;
  assign go_evt   = wr_cmd & wdata[0] & ~start_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      go_q    <= 1'b0;
    end else begin
      go_q <= go_evt;
      if (wr_cmd) begin
        start_q <= wdata[0];
        dir_q   <= wdata[3];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 2'b00;
      flag_q <= 1'b0;
      req_q  <= 1'b0;
      time_q <= '0;
    end else begin
      req_q  <= irq_in;
      flag_q <= flag_next(flag_q, irq_rise, wr_stat, wdata[2]);
      if (wr_stat) hi_q   <= wdata[6:5];
      if (wr_time) time_q <= wdata;
    end
  end

  assign cmd_byte  = {4'b0000, dir_q, 2'b00, start_q};
  assign stat_byte = stat_pack(hi_q, flag_q, busy_in);
  assign time_byte = time_q;
  assign irq_flag  = req_q;
  assign go_pulse  = go_q;

  // R5: the strobe never lasts two cycles
  p_go_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |=> !go_pulse);
  // R5: a strobe is always followed by a stored start bit
  p_go_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse |-> cmd_byte[0]);
  // R7: the stored request follows the input one edge later
  p_req_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_in |=> irq_flag);
  p_req_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_in |=> !irq_flag);
  // R10: a rise always leaves the status flag set
  p_rise_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> stat_byte[2]);

endmodule

// File: rtl/dmareg_mode.sv
module dmareg_mode
  import dmareg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic [NUM_CH-1:0] wblk,
  input  logic [NUM_CH-1:0] req,
  output logic [BYTE_W-1:0] mode_byte,
  output logic              host_irq
);

  logic [NUM_CH-1:0] blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       blk_q <= '0;
    else if (wr_mode) blk_q <= wblk;
  end

  assign mode_byte = mode_pack(req, blk_q);
  assign host_irq  = irq_merge(req, blk_q);

  // R8: with every channel blocked the host line stays low
  p_all_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (&blk_q) |-> !host_irq);
  // R8: the host line is only high when some request is stored
  p_irq_needs_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (|req));
  // R6: a mode write stores exactly the written block bits
  p_mode_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_byte[BLK_LSB +: NUM_CH] == $past(wblk)));

endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
  import dmareg_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  input  logic [NUM_CH-1:0] chan_irq,
  input  logic [NUM_CH-1:0] chan_busy,
  output logic              host_irq,
  output logic [NUM_CH-1:0] dma_go
);

  localparam int CH_BIT  = 3;   // 8-byte slot per channel
  localparam int WIN_BIT = 2;   // upper half of a slot is the descriptor port

  // all ones over the access width
  function automatic logic [DATA_W-1:0] fill_ones(input logic [1:0] sz);
    int nbits;
    logic [DATA_W-1:0] v;
    nbits = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    for (int i = 0; i < DATA_W; i++) v[i] = (i < nbits);
    return v;
  endfunction

  logic     byte_acc, in_bank, wr_hit, ch_sel;
  reg_sel_e sel;
  logic [BYTE_W-1:0] wbyte;

  assign byte_acc = (acc_size == 2'd0);
  assign in_bank  = ~acc_addr[WIN_BIT];
  assign sel      = reg_sel_e'(acc_addr[1:0]);
  assign ch_sel   = acc_addr[CH_BIT];
  assign wbyte    = acc_wdata[BYTE_W-1:0];
  assign wr_hit   = acc_valid & acc_write & byte_acc & in_bank;

  logic unused_hi;
  assign unused_hi = ^acc_wdata[DATA_W-1:BYTE_W];

  logic [NUM_CH-1:0][BYTE_W-1:0] cmd_b, stat_b, time_b;
  logic [NUM_CH-1:0]             req;
  logic [BYTE_W-1:0]             mode_b;
  logic                          wr_mode;

  assign wr_mode = wr_hit & (sel == REG_MODE);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic mine;
    assign mine = (ch_sel == 1'(c));
    dmareg_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd   (wr_hit & mine & (sel == REG_CMD)),
      .wr_stat  (wr_hit & mine & (sel == REG_STAT)),
      .wr_time  (wr_hit & mine & (sel == REG_TIME)),
      .wdata    (wbyte),
      .irq_in   (chan_irq[c]),
      .busy_in  (chan_busy[c]),
      .cmd_byte (cmd_b[c]),
      .stat_byte(stat_b[c]),
      .time_byte(time_b[c]),
      .irq_flag (req[c]),
      .go_pulse (dma_go[c])
    );
  end

  dmareg_mode u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mode  (wr_mode),
    .wblk     (wbyte[BLK_LSB +: NUM_CH]),
    .req      (req),
    .mode_byte(mode_b),
    .host_irq (host_irq)
  );

  always_comb begin
    acc_rdata = fill_ones(acc_size);
    if (byte_acc && in_bank) begin
      acc_rdata = '0;
      unique case (sel)
        REG_CMD:  acc_rdata[BYTE_W-1:0] = cmd_b[ch_sel];
        REG_MODE: acc_rdata[BYTE_W-1:0] = mode_b;
        REG_STAT: acc_rdata[BYTE_W-1:0] = stat_b[ch_sel];
        default:  acc_rdata[BYTE_W-1:0] = time_b[ch_sel];
      endcase
    end
  end

  // R2: a wide write leaves every stored byte untouched
  p_wide_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_size != 2'd0)
      |=> ($stable(time_b) && $stable(cmd_b) && $stable(mode_b[BLK_LSB +: NUM_CH])));
  // R3: a descriptor-port write leaves the bank untouched
  p_desc_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && acc_addr[WIN_BIT])
      |=> ($stable(time_b) && $stable(cmd_b) && $stable(mode_b[BLK_LSB +: NUM_CH])));
  // R2: a two-byte read always shows all ones in the low half
  p_wide_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_size == 2'd1) |-> (acc_rdata[15:0] == 16'hFFFF));

endmodule

// File: tb/sim_dmareg_bank.sv
module sim_dmareg_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [3:0]  acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic [31:0] acc_wdata = '0;
  logic [31:0] acc_rdata;
  logic [1:0]  chan_irq = '0, chan_busy = '0;
  logic        host_irq;
  logic [1:0]  dma_go;

  always #(CLK_PERIOD/2) clk = ~clk;

  dmareg_bank u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .chan_irq(chan_irq), .chan_busy(chan_busy),
    .host_irq(host_irq), .dma_go(dma_go)
  );

  int checks = 0;
  int fails  = 0;

  // behavioural model: one entry per channel
  int m_start[2], m_dir[2], m_hi[2], m_flag[2], m_req[2], m_blk[2], m_time[2], m_go[2];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      m_start[c] = 0; m_dir[c] = 0; m_hi[c] = 0; m_flag[c] = 0;
      m_req[c] = 0; m_blk[c] = 0; m_time[c] = 0; m_go[c] = 0;
    end
  endtask

  task automatic model_step(input logic v, input logic w, input logic [3:0] a,
                            input logic [1:0] s, input logic [31:0] d,
                            input logic [1:0] irq);
    bit hit;
    int c;
    int r;
    hit = v && w && (s == 0) && !a[2];
    c = a[3];
    r = a[1:0];
    for (int k = 0; k < 2; k++) begin
      bit rise;
      bit clr;
      rise = irq[k] && (m_req[k] == 0);
      clr  = hit && c == k && r == 2 && d[2];
      m_go[k] = (hit && c == k && r == 0 && d[0] && m_start[k] == 0) ? 1 : 0;
      if (rise) m_flag[k] = 1;
      else if (clr) m_flag[k] = 0;
      m_req[k] = irq[k];
    end
    if (hit) begin
      case (r)
        0: begin m_start[c] = d[0]; m_dir[c] = d[3]; end
        1: begin m_blk[0] = d[4]; m_blk[1] = d[5]; end
        2: m_hi[c] = d[6:5];
        default: m_time[c] = d[7:0];
      endcase
    end
  endtask

  function automatic logic [31:0] model_read(input logic [3:0] a, input logic [1:0] s,
                                             input logic [1:0] busy);
    int c;
    c = a[3];
    if (s == 1) return 32'h0000FFFF;
    if (s != 0) return 32'hFFFFFFFF;
    if (a[2]) return 32'h000000FF;
    case (a[1:0])
      2'd0: return 32'(m_start[c] + 8 * m_dir[c]);
      2'd1: return 32'(4 * m_req[0] + 8 * m_req[1] + 16 * m_blk[0] + 32 * m_blk[1]);
      2'd2: return 32'(32 * m_hi[c] + 4 * m_flag[c] + busy[c]);
      default: return 32'(m_time[c]);
    endcase
  endfunction

  // one clock: drive at falling edge, model steps after the rising edge, compare
  task automatic cyc(input logic v, input logic w, input logic [3:0] a,
                     input logic [1:0] s, input logic [31:0] d);
    logic exp_irq;
    acc_valid = v; acc_write = w; acc_addr = a; acc_size = s; acc_wdata = d;
    @(posedge clk);
    @(negedge clk);
    model_step(v, w, a, s, d, chan_irq);
    exp_irq = ((m_req[0] && !m_blk[0]) || (m_req[1] && !m_blk[1]));
    chk("MODEL host_irq R8", 32'(host_irq), 32'(exp_irq));
    chk("MODEL dma_go R5", 32'(dma_go), 32'(m_go[0] + 2 * m_go[1]));
    chk("MODEL rdata R3", acc_rdata, model_read(a, s, chan_busy));
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cyc(1'b1, 1'b1, a, 2'd0, {24'h0, d});
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [1:0] s,
                    input logic [31:0] exp);
    cyc(1'b1, 1'b0, a, s, 32'h0);
    chk(tag, acc_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog R1 actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 host_irq", 32'(host_irq), 32'h0);
    chk("R1 dma_go", 32'(dma_go), 32'h0);
    for (int a = 0; a < 16; a++)
      if (a[2] == 1'b0) rd("R1 reset byte", 4'(a), 2'd0, 32'h0);

    // R11: timing bytes per channel
    wr(4'd3, 8'hA5);
    wr(4'd11, 8'h3C);
    rd("R11 ch0 timing", 4'd3, 2'd0, 32'hA5);
    rd("R11 ch1 timing", 4'd11, 2'd0, 32'h3C);

    // R4 / R5: command and start strobe
    wr(4'd0, 8'hF6);
    chk("R5 no strobe on bit0=0", 32'(dma_go), 32'h0);
    rd("R4 command keeps bits 0,3 only", 4'd0, 2'd0, 32'h00);
    wr(4'd0, 8'hFF);
    chk("R5 strobe ch0", 32'(dma_go), 32'h1);
    rd("R4 command 0x09", 4'd0, 2'd0, 32'h09);
    chk("R5 strobe one cycle", 32'(dma_go), 32'h0);
    wr(4'd0, 8'h01);
    chk("R5 no strobe on rewrite", 32'(dma_go), 32'h0);
    wr(4'd0, 8'h00);
    wr(4'd0, 8'h01);
    chk("R5 strobe after re-arm", 32'(dma_go), 32'h1);
    wr(4'd8, 8'h09);
    chk("R5 strobe ch1", 32'(dma_go), 32'h2);

    // R2: access size
    cyc(1'b1, 1'b1, 4'd3, 2'd1, 32'hFFFFFFFF);
    rd("R2 two-byte write ignored", 4'd3, 2'd0, 32'hA5);
    cyc(1'b1, 1'b1, 4'd11, 2'd2, 32'h00000000);
    rd("R2 four-byte write ignored", 4'd11, 2'd0, 32'h3C);
    rd("R2 two-byte read", 4'd0, 2'd1, 32'h0000FFFF);
    rd("R2 four-byte read", 4'd0, 2'd2, 32'hFFFFFFFF);
    rd("R2 size-3 read", 4'd2, 2'd3, 32'hFFFFFFFF);

    // R3: descriptor port not decoded
    rd("R3 descriptor byte read", 4'd4, 2'd0, 32'hFF);
    wr(4'd7, 8'h00);
    rd("R3 offset 7 write ignored", 4'd3, 2'd0, 32'hA5);
    wr(4'd15, 8'h00);
    rd("R3 offset 15 write ignored", 4'd11, 2'd0, 32'h3C);

    // R6: shared mode byte
    wr(4'd1, 8'hFF);
    rd("R6 mode write only blocks", 4'd1, 2'd0, 32'h30);
    rd("R6 mode shared via ch1", 4'd9, 2'd0, 32'h30);
    wr(4'd9, 8'h00);
    rd("R6 mode cleared via ch1", 4'd1, 2'd0, 32'h00);

    // R7 / R8: requests and merge
    chan_irq = 2'b01;
    cyc(1'b0, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R8 host_irq ch0", 32'(host_irq), 32'h1);
    rd("R7 ch0 request bit", 4'd1, 2'd0, 32'h04);
    wr(4'd1, 8'h10);
    chk("R8 ch0 blocked", 32'(host_irq), 32'h0);
    chan_irq = 2'b11;
    cyc(1'b0, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R8 ch1 passes", 32'(host_irq), 32'h1);
    rd("R7 both requests", 4'd9, 2'd0, 32'h1C);
    wr(4'd1, 8'h30);
    chk("R8 both blocked", 32'(host_irq), 32'h0);
    wr(4'd1, 8'h00);
    chk("R8 unblocked", 32'(host_irq), 32'h1);
    chan_irq = 2'b00;
    cyc(1'b0, 1'b0, 4'd0, 2'd0, 32'h0);
    chk("R8 requests gone", 32'(host_irq), 32'h0);
    rd("R7 requests cleared", 4'd1, 2'd0, 32'h00);

    // R10: status interrupt flag
    rd("R10 ch0 flag set", 4'd2, 2'd0, 32'h04);
    rd("R10 ch1 flag set", 4'd10, 2'd0, 32'h04);
    wr(4'd2, 8'h04);
    rd("R10 ch0 flag cleared", 4'd2, 2'd0, 32'h00);
    wr(4'd10, 8'h00);
    rd("R10 zero keeps flag", 4'd10, 2'd0, 32'h04);
    chan_irq = 2'b01;
    wr(4'd2, 8'h04);
    rd("R10 set wins over clear", 4'd2, 2'd0, 32'h04);
    wr(4'd2, 8'h04);
    rd("R10 cleared without new rise", 4'd2, 2'd0, 32'h00);
    chan_irq = 2'b00;

    // R9: status fields
    wr(4'd2, 8'hFF);
    rd("R9 writable bits 6:5", 4'd2, 2'd0, 32'h60);
    chan_busy = 2'b01;
    rd("R9 busy ch0", 4'd2, 2'd0, 32'h61);
    chan_busy = 2'b10;
    rd("R9 busy ch1", 4'd10, 2'd0, 32'h05);
    chan_busy = 2'b00;

    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] sz;
      sz = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      if ($urandom_range(0, 5) == 0) chan_irq = 2'($urandom);
      if ($urandom_range(0, 5) == 0) chan_busy = 2'($urandom);
      cyc(1'($urandom), 1'($urandom), 4'($urandom), sz, $urandom);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule